// File: doc/BRIEF.md
# Transmit Laser Safety Sequencer

This block decides when the laser of an optical transmitter may emit light. It watches a power-good indication, an already synchronized transmit-disable request and a raw laser-fault detect. From these it drives the laser enable, a latched fault status and a ready indication. Every timing window is a clock-cycle count set by a parameter.

A detected fault turns the laser off and is held. The fault is kept until supply power is lost, or until disable is held high long enough and then released. After a valid release the transmitter re-initializes. If the fault is still present at that point, it is caught again at once.

While power is not good, or while disable is high, the laser stays dark. At power-up the laser also stays dark until disable is driven low.

Top module: `tx_safety_seq`

## Requirements
- R1: While reset is asserted or `pwr_good` is low, `laser_en`, `tx_ready` and `tx_fault` are all 0.
- R2: When `pwr_good` rises while `tx_dis` is high, `laser_en` stays 0 for as long as `tx_dis` stays high.
- R3: The cycle after `tx_dis` is sampled low with no latched fault, `laser_en` is 1 and `tx_ready` is 0. `tx_ready` becomes 1 exactly `INIT_CYC` cycles after `laser_en` rose, provided neither disable nor fault occurs in between.
- R4: A clock edge at which `tx_dis` is sampled high gives `laser_en` = 0 and `tx_ready` = 0 in the following cycle.
- R5: A `laser_fault` sampled high while the laser is enabled, with `tx_dis` low, gives `tx_fault` = 1 and `laser_en` = 0 in the following cycle.
- R6: `tx_fault` stays 1 after `laser_fault` returns low, including while disable is held. The laser stays off for as long as `tx_fault` is 1.
- R7: A disable pulse that is sampled high at fewer than `HOLD_CYC` edges after the edge that entered the disabled state leaves the fault latched. On release the block returns to the faulted state.
- R8: A disable pulse that is sampled high at `HOLD_CYC` or more such edges clears `tx_fault` on release and starts re-initialization as in R3.
- R9: If `laser_fault` is still high after a valid clearing release, `tx_fault` returns to 1 and `laser_en` to 0 one cycle after re-initialization starts.
- R10: `laser_fault` is ignored while disabled. A fault pulse inside a disable period, with no latched fault, leaves `tx_fault` at 0, and release leads to normal start-up.
- R11: When `tx_dis` and `laser_fault` are first sampled high at the same edge, disable wins and `tx_fault` stays 0.
- R12: Loss of `pwr_good` clears a latched fault. When power returns with `tx_dis` low, start-up begins without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply within range |
| tx_dis | input | 1 | Synchronized effective transmit disable |
| laser_fault | input | 1 | Raw laser power out-of-range detect |
| laser_en | output | 1 | Laser driver enable |
| tx_fault | output | 1 | Latched fault status |
| tx_ready | output | 1 | Transmitter initialized and emitting |

## Verification
The bench builds the block with `HOLD_CYC` = 4 and `INIT_CYC` = 6. With these values, disable pulses exactly one edge short of the clearing hold, and exactly at it, can both be driven. Several complete re-initialization windows also fit in a short run. A behavioural model runs alongside the design and is compared on every cycle. Directed checks cover the persistent-fault retrigger, fault masking during disable, and the clearing of the latch on power loss.

// File: rtl/tx_safety_seq.sv
module tx_safety_seq #(
  parameter int HOLD_CYC = 1000,
  parameter int INIT_CYC = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic tx_dis,
  input  logic laser_fault,
  output logic laser_en,
  output logic tx_fault,
  output logic tx_ready
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  typedef enum logic [2:0] {ST_OFF, ST_INIT, ST_RUN, ST_DIS, ST_FLT} st_t;

  st_t           st_q, st_d;
  logic          latch_q, latch_d;
  logic [HW-1:0] hold_q;
  logic [IW-1:0] init_q;

  wire hold_ok   = (hold_q >= HW'(HOLD_CYC));
  wire init_done = (init_q == IW'(INIT_CYC - 1));

  always_comb begin
    st_d    = st_q;
    latch_d = latch_q;
    if (!pwr_good) begin
      st_d    = ST_OFF;
      latch_d = 1'b0;
    end else begin
      case (st_q)
        ST_OFF:  st_d = tx_dis ? ST_DIS : ST_INIT;
        ST_INIT: begin
          if (tx_dis) st_d = ST_DIS;
          else if (laser_fault) begin
            st_d    = ST_FLT;
            latch_d = 1'b1;
          end else if (init_done) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (tx_dis) st_d = ST_DIS;
          else if (laser_fault) begin
            st_d    = ST_FLT;
            latch_d = 1'b1;
          end
        end
        ST_DIS: begin
          if (!tx_dis) begin
            if (latch_q && !hold_ok) st_d = ST_FLT;
            else begin
              st_d    = ST_INIT;
              latch_d = 1'b0;
            end
          end
        end
        ST_FLT:  if (tx_dis) st_d = ST_DIS;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      latch_q <= 1'b0;
      hold_q  <= '0;
      init_q  <= '0;
    end else begin
      st_q    <= st_d;
      latch_q <= latch_d;
      if (st_q != ST_DIS)           hold_q <= '0;
      else if (tx_dis && !hold_ok)  hold_q <= hold_q + 1'b1;
      if (st_q != ST_INIT)          init_q <= '0;
      else if (!init_done)          init_q <= init_q + 1'b1;
    end
  end

  assign laser_en = (st_q == ST_INIT) || (st_q == ST_RUN);
  assign tx_ready = (st_q == ST_RUN);
  assign tx_fault = latch_q;
endmodule

// File: rtl/tx_safety_seq_chk.sv
module tx_safety_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic tx_dis,
  input logic laser_fault,
  input logic laser_en,
  input logic tx_fault,
  input logic tx_ready
);
  assert_power_loss_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!laser_en && !tx_fault && !tx_ready));

  assert_disable_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dis |=> (!laser_en && !tx_ready));

  assert_fault_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && laser_en && !tx_dis && laser_fault) |=> tx_fault);

  assert_fault_keeps_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fault |-> !laser_en);

  assert_clear_only_by_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_fault) |-> ($past(!pwr_good) || $past(!tx_dis)));

  assert_ready_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(laser_en));

  assert_ready_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> laser_en);
endmodule

bind tx_safety_seq tx_safety_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tx_dis(tx_dis),
  .laser_fault(laser_fault), .laser_en(laser_en), .tx_fault(tx_fault),
  .tx_ready(tx_ready)
);

// File: tb/tx_safety_seq_bench.sv
module tx_safety_seq_bench;
  localparam int HOLD = 4;
  localparam int INIT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic tx_dis = 1'b1;
  logic laser_fault = 1'b0;
  logic laser_en, tx_fault, tx_ready;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tx_safety_seq #(.HOLD_CYC(HOLD), .INIT_CYC(INIT)) u_tx_safety_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tx_dis(tx_dis),
    .laser_fault(laser_fault), .laser_en(laser_en), .tx_fault(tx_fault),
    .tx_ready(tx_ready)
  );

  // behavioural reference: 0 dark, 1 warming, 2 live, 3 held off, 4 tripped
  int m_mode = 0;
  int m_age = 0;
  int m_t = 0;
  bit m_lat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_lat = 0; m_age = 0; m_t = 0;
    end else if (!pwr_good) begin
      m_mode = 0; m_lat = 0;
    end else begin
      case (m_mode)
        0: if (tx_dis) begin m_mode = 3; m_age = 0; end
           else begin m_mode = 1; m_t = 0; end
        1: if (tx_dis) begin m_mode = 3; m_age = 0; end
           else if (laser_fault) begin m_mode = 4; m_lat = 1; end
           else begin m_t++; if (m_t == INIT) m_mode = 2; end
        2: if (tx_dis) begin m_mode = 3; m_age = 0; end
           else if (laser_fault) begin m_mode = 4; m_lat = 1; end
        3: if (tx_dis) m_age++;
           else if (m_lat && m_age < HOLD) m_mode = 4;
           else begin m_mode = 1; m_t = 0; m_lat = 0; end
        default: if (tx_dis) begin m_mode = 3; m_age = 0; end
      endcase
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R4", "model laser_en", laser_en, (m_mode == 1 || m_mode == 2));
      chk("R3", "model tx_ready", tx_ready, (m_mode == 2));
      chk("R6", "model tx_fault", tx_fault, m_lat);
    end
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1", "reset laser_en", laser_en, 1'b0);
    chk("R1", "reset tx_fault", tx_fault, 1'b0);
    chk("R1", "reset tx_ready", tx_ready, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "no power laser_en", laser_en, 1'b0);

    pwr_good = 1'b1;
    step(5);
    chk("R2", "powered, disabled laser_en", laser_en, 1'b0);

    tx_dis = 1'b0;
    step(1);
    chk("R3", "init laser_en", laser_en, 1'b1);
    chk("R3", "init tx_ready", tx_ready, 1'b0);
    step(INIT - 1);
    chk("R3", "ready one cycle early", tx_ready, 1'b0);
    step(1);
    chk("R3", "ready on time", tx_ready, 1'b1);

    tx_dis = 1'b1;
    step(1);
    chk("R4", "disable laser_en", laser_en, 1'b0);
    chk("R4", "disable tx_ready", tx_ready, 1'b0);
    tx_dis = 1'b0;
    step(INIT + 1);

    laser_fault = 1'b1;
    step(1);
    chk("R5", "fault tx_fault", tx_fault, 1'b1);
    chk("R5", "fault laser_en", laser_en, 1'b0);
    laser_fault = 1'b0;
    step(5);
    chk("R6", "latched tx_fault", tx_fault, 1'b1);

    tx_dis = 1'b1;
    step(HOLD);
    tx_dis = 1'b0;
    step(1);
    chk("R7", "short pulse tx_fault", tx_fault, 1'b1);
    chk("R7", "short pulse laser_en", laser_en, 1'b0);

    tx_dis = 1'b1;
    step(HOLD + 1);
    chk("R6", "held during disable tx_fault", tx_fault, 1'b1);
    tx_dis = 1'b0;
    step(1);
    chk("R8", "long pulse tx_fault", tx_fault, 1'b0);
    chk("R8", "long pulse laser_en", laser_en, 1'b1);
    step(INIT);
    chk("R8", "long pulse tx_ready", tx_ready, 1'b1);

    laser_fault = 1'b1;
    step(1);
    tx_dis = 1'b1;
    step(HOLD + 1);
    tx_dis = 1'b0;
    step(1);
    chk("R9", "retry init laser_en", laser_en, 1'b1);
    step(1);
    chk("R9", "retrigger tx_fault", tx_fault, 1'b1);
    chk("R9", "retrigger laser_en", laser_en, 1'b0);
    laser_fault = 1'b0;
    tx_dis = 1'b1;
    step(HOLD + 2);
    tx_dis = 1'b0;
    step(INIT + 1);

    tx_dis = 1'b1;
    step(2);
    laser_fault = 1'b1;
    step(2);
    chk("R10", "masked fault tx_fault", tx_fault, 1'b0);
    laser_fault = 1'b0;
    step(1);
    tx_dis = 1'b0;
    step(INIT + 1);
    chk("R10", "start after masked fault tx_ready", tx_ready, 1'b1);
    chk("R10", "start after masked fault tx_fault", tx_fault, 1'b0);

    tx_dis = 1'b1;
    laser_fault = 1'b1;
    step(1);
    chk("R11", "simultaneous tx_fault", tx_fault, 1'b0);
    chk("R11", "simultaneous laser_en", laser_en, 1'b0);
    laser_fault = 1'b0;
    tx_dis = 1'b0;
    step(INIT + 1);

    laser_fault = 1'b1;
    step(1);
    laser_fault = 1'b0;
    pwr_good = 1'b0;
    step(1);
    chk("R12", "power loss tx_fault", tx_fault, 1'b0);
    chk("R12", "power loss laser_en", laser_en, 1'b0);
    pwr_good = 1'b1;
    step(1);
    chk("R12", "power back laser_en", laser_en, 1'b1);
    chk("R12", "power back tx_fault", tx_fault, 1'b0);
    step(INIT + 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule